// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block is the digital controller that runs the self-calibration pass of a pipelined converter. A start request arrives on a pin that is not tied to the converter clock. The block brings that pin into the clock domain through a chain of flip-flops. It accepts the request only after it has stayed high long enough. It then holds the converter in a busy state for a fixed number of clocks. While the block is busy, the calibration-complete output is low and the conversion-enable output to the datapath is withheld. Both outputs return high together when the interval ends.

The measurement itself is not part of this block. A slot counter stands in for it: it splits the interval into equal slots and raises a one-clock write strobe, with an ascending address, at the end of each slot. A coefficient memory can hang on that strobe. The calibration length, the minimum request width, the synchronizer depth and the number of coefficient words are all parameters. A generate option removes the write hook.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, `cal_done` and `conv_en` are 1, `coef_we` is 0, and the block stays idle until a qualified request arrives.
- R2: `cal_start` passes through `SYNC_STAGES` (default 2) flip-flops before use. A request is qualified only if the synchronized level shows a rising edge and then stays high for `MIN_HIGH` (default 4) consecutive clocks. A shorter pulse leaves `cal_done` at 1.
- R3: With the default parameters, `cal_done` falls at the 6th rising clock edge after the first edge that samples `cal_start` high. That is one clock after the request qualifies.
- R4: `cal_done` stays 0 for exactly `CAL_CYCLES` clocks (default 17400) and then returns to 1.
- R5: `conv_en` is 0 exactly while `cal_done` is 0.
- R6: A request that qualifies while a calibration is running is ignored, and the running count is not restarted: the end time does not move.
- R7: A request that stays high past qualification, even beyond the end of the calibration it started, starts only one calibration. A new calibration needs the level to go low and rise again.
- R8: The interval is split into slots of `CAL_CYCLES/COEF_WORDS` clocks. `coef_we` is high for one clock at the end of each slot, at most `COEF_WORDS` times per calibration, and only while `cal_done` is 0. Write j (counting from 0) is visible after edge F + (j+1)*SLOT - 1, where F is the edge at which `cal_done` fell. `coef_addr` carries j.
- R9: Each new calibration starts its coefficient addresses again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; runs without pause during calibration |
| rst_n | input | 1 | Active-low reset, synchronous release |
| cal_start | input | 1 | Asynchronous start request, active high |
| cal_done | output | 1 | 1 = normal conversion, 0 = calibration running |
| conv_en | output | 1 | Enables normal conversion in the datapath |
| coef_we | output | 1 | One-clock write strobe for the coefficient memory |
| coef_addr | output | $clog2(COEF_WORDS) | Coefficient word address for `coef_we` |

## Verification
The assertions assume that `clk` keeps running from reset onward. They also assume that any request which qualifies respects the upper window: it falls before the calibration it started would otherwise be followed by a second one. The exception is the deliberate held-high case, where the assertions rely on the block's saturating width counter to suppress a retrigger.

The bench changes `cal_start` only on falling clock edges. This makes the synchronizer latency exact, so the scoreboard can predict the edge-accurate times of the busy interval and of each coefficient write. A shorter calibration length is used to keep runs brief, and the requests cover a too-short pulse, a pulse at the minimum width, a pulse inside a running calibration, a pulse held past the end, and a repeat run.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cal_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/cal_req_qual.sv
module cal_req_qual #(
   parameter int MIN_HIGH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic trig_o
);
   localparam int HW = $clog2(MIN_HIGH + 1);

   logic          req_d;
   logic          rise;
   logic [HW-1:0] hcnt;

   generate
      if (MIN_HIGH < 2) begin : g_bad_min
         $error("cal_req_qual: MIN_HIGH must be at least 2");
      end
   endgenerate

   assign rise = req_i & ~req_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_d  <= 1'b0;
         hcnt   <= '0;
         trig_o <= 1'b0;
      end else begin
         req_d  <= req_i;
         trig_o <= req_i && !rise && (hcnt == HW'(MIN_HIGH - 1));
         if (rise)
            hcnt <= HW'(1);
         else if (!req_i)
            hcnt <= '0;
         else if (hcnt != '0 && hcnt != HW'(MIN_HIGH))
            hcnt <= hcnt + 1'b1;
      end
   end

   // R7
   single_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o);

   // R2
   trig_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> $past(req_i));
endmodule

// File: rtl/cal_timer.sv
module cal_timer
   import cal_seq_pkg::*;
#(
   parameter int CAL_CYCLES = 17400,
   parameter int COEF_WORDS = 16,
   parameter bit COEF_EN    = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          trig_i,
   output logic                          cal_done_o,
   output logic                          conv_en_o,
   output logic                          coef_we_o,
   output logic [$clog2(COEF_WORDS)-1:0] coef_addr_o
);
   localparam int CW   = $clog2(CAL_CYCLES + 1);
   localparam int SLOT = CAL_CYCLES / COEF_WORDS;
   localparam int SW   = $clog2(SLOT + 1);
   localparam int AW   = $clog2(COEF_WORDS);
   localparam int WCW  = AW + 1;

   seq_state_e     state;
   logic [CW-1:0]  cnt;
   logic [SW-1:0]  scnt;
   logic [WCW-1:0] waddr;
   logic           last;
   logic           slot_hit;

   generate
      if (CAL_CYCLES < 2) begin : g_bad_len
         $error("cal_timer: CAL_CYCLES must be at least 2");
      end
      if (COEF_WORDS < 2 || SLOT < 1) begin : g_bad_words
         $error("cal_timer: COEF_WORDS must be in 2..CAL_CYCLES");
      end
   endgenerate

   assign last     = (cnt == CW'(CAL_CYCLES - 1));
   assign slot_hit = (state == SEQ_RUN) && (scnt == SW'(SLOT - 1))
                     && (waddr < WCW'(COEF_WORDS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
         scnt  <= '0;
         waddr <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (trig_i) begin
                  state <= SEQ_RUN;
                  cnt   <= '0;
                  scnt  <= '0;
                  waddr <= '0;
               end
            end
            SEQ_RUN: begin
               if (last) state <= SEQ_IDLE;
               else      cnt   <= cnt + 1'b1;
               if (slot_hit) begin
                  scnt  <= '0;
                  waddr <= waddr + 1'b1;
               end else begin
                  scnt <= scnt + 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign cal_done_o = (state == SEQ_IDLE);
   assign conv_en_o  = (state == SEQ_IDLE);

   generate
      if (COEF_EN) begin : g_hook
         assign coef_we_o   = slot_hit;
         assign coef_addr_o = waddr[AW-1:0];
      end else begin : g_no_hook
         assign coef_we_o   = 1'b0;
         assign coef_addr_o = '0;
      end
   endgenerate

   // R3
   fall_after_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cal_done_o) |-> $past(trig_i));

   // R3
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done_o && trig_i) |=> !cal_done_o);

   // R6
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_done_o && !last) |=> (!cal_done_o && cnt == $past(cnt) + 1'b1));

   // R4
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_done_o) |-> $past(cnt) == CW'(CAL_CYCLES - 1));

   // R8
   coef_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coef_we_o |-> !cal_done_o);

   // R9
   addr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cal_done_o) |-> waddr == '0);
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
   parameter int CAL_CYCLES  = 17400,
   parameter int MIN_HIGH    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int COEF_WORDS  = 16,
   parameter bit COEF_EN     = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cal_start,
   output logic                          cal_done,
   output logic                          conv_en,
   output logic                          coef_we,
   output logic [$clog2(COEF_WORDS)-1:0] coef_addr
);
   logic req_sync;
   logic trig;

   cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cal_start),
      .dout (req_sync)
   );

   cal_req_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req_sync),
      .trig_o(trig)
   );

   cal_timer #(
      .CAL_CYCLES(CAL_CYCLES),
      .COEF_WORDS(COEF_WORDS),
      .COEF_EN   (COEF_EN)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (trig),
      .cal_done_o (cal_done),
      .conv_en_o  (conv_en),
      .coef_we_o  (coef_we),
      .coef_addr_o(coef_addr)
   );

   // R5
   conv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coef_we |-> !conv_en);
endmodule

// File: tb/sim_cal_sequencer.sv
module sim_cal_sequencer;
   localparam int CAL  = 600;
   localparam int NW   = 8;
   localparam int SLOT = CAL / NW;
   localparam int AW   = $clog2(NW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cal_start = 1'b0;
   logic          cal_done;
   logic          conv_en;
   logic          coef_we;
   logic [AW-1:0] coef_addr;

   typedef struct {int kind; int cyc; int val;} ev_t;
   ev_t q[$];

   int cyc = 0;
   int checks = 0;
   int bad = 0;
   int busy_end = -1;
   bit mon_on = 1'b0;
   logic prev_done = 1'b1;

   cal_sequencer #(.CAL_CYCLES(CAL), .COEF_WORDS(NW)) u0 (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
      .cal_done(cal_done), .conv_en(conv_en),
      .coef_we(coef_we), .coef_addr(coef_addr)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic expect_ev(int kind, int val, string req);
      ev_t e;
      if (q.size() == 0) begin
         check(1'b0, {req, " unexpected event"}, kind, -1);
      end else begin
         e = q.pop_front();
         check(e.kind == kind, {req, " event kind"}, kind, e.kind);
         check(e.cyc == cyc, {req, " event cycle"}, cyc, e.cyc);
         check(e.val == val, {req, " event value"}, val, e.val);
      end
   endtask

   // driver: raises cal_start for 'width' rising edges and predicts events
   task automatic request(int width);
      int p0;
      int f;
      @(negedge clk);
      cal_start = 1'b1;
      p0 = cyc + 1;
      if (width >= 4 && p0 + 4 >= busy_end) begin
         f = p0 + 6;
         q.push_back('{0, f, 0});
         for (int j = 0; j < NW; j++) q.push_back('{2, f + (j + 1) * SLOT - 1, j});
         q.push_back('{1, f + CAL, 0});
         busy_end = f + CAL;
      end
      repeat (width) @(negedge clk);
      cal_start = 1'b0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (mon_on) begin
         if (cal_done !== prev_done) begin
            if (prev_done) expect_ev(0, 0, "R3 fall");
            else           expect_ev(1, 0, "R4 rise");
            prev_done = cal_done;
         end
         if (conv_en !== cal_done) check(1'b0, "R5 conv_en", conv_en, cal_done);
         if (coef_we === 1'b1) expect_ev(2, int'(coef_addr), "R8/R9 coef write");
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cal_done === 1'b1, "R1 cal_done", cal_done, 1);
      check(conv_en === 1'b1, "R1 conv_en", conv_en, 1);
      check(coef_we === 1'b0, "R1 coef_we", coef_we, 0);
      mon_on = 1'b1;

      // R2: three-clock pulse is ignored
      request(3);
      repeat (20) @(negedge clk);
      check(cal_done === 1'b1, "R2 short pulse ignored", cal_done, 1);

      // R2/R3/R4: minimum width pulse
      request(4);
      repeat (200) @(negedge clk);
      check(cal_done === 1'b0, "R4 busy mid-run", cal_done, 0);
      // R6: second request inside the run
      request(6);
      repeat (20) @(negedge clk);
      check(cal_done === 1'b0, "R6 still busy", cal_done, 0);
      repeat (CAL) @(negedge clk);
      check(cal_done === 1'b1, "R4 back to normal", cal_done, 1);

      // R7: request held past the end of its calibration
      request(CAL + 50);
      repeat (100) @(negedge clk);
      check(cal_done === 1'b1, "R7 no retrigger", cal_done, 1);
      check(conv_en === 1'b1, "R7 conv_en", conv_en, 1);

      // R9: fresh calibration restarts addresses
      request(9);
      repeat (CAL + 30) @(negedge clk);
      check(q.size() == 0, "R8 all predicted events seen", q.size(), 0);
      check(cal_done === 1'b1, "R9 idle at end", cal_done, 1);

      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule